// File: doc/BRIEF.md
# DS3 M23 Transmit Overhead Inserter

This block sits on the transmit side of a DS3 line path. It receives a serial payload bit stream, one bit per clock cycle in which the bit enable is high, and emits the same stream with every overhead slot of the M23 multiframe replaced by a locally generated value. A multiframe holds seven subframes. Each subframe holds eight blocks, and each block is one overhead bit followed by 84 payload bits, so one multiframe is 4760 bits long. An internal position counter tracks where the current bit falls in the multiframe. That position decides whether the output bit is the payload bit or an overhead value.

The overhead values come from several sources. The alignment patterns are fixed constants. The remote defect indication is chosen by a mode select: it can follow the defect input or be forced to either level. The parity slots carry the parity of the previous multiframe's payload. The stuff-control slots repeat a per-tributary value that is captured once per multiframe. A start-of-multiframe flag marks the first bit of each multiframe. Line coding and the multiplexing of tributaries are handled elsewhere.

Top module: `m23_oh_inserter`

## Requirements
- R1: After synchronous active-low reset, `ser_out` and `mf_sof` are 0, and the first enabled bit is treated as position 0 of a multiframe (the X1 slot).
- R2: A multiframe is 4760 enabled bits (7 subframes × 8 blocks × 85 bits). The first bit of each block is overhead. Every other bit is copied from `pay_in` to `ser_out`. Position 0 follows position 4759.
- R3: The position counter advances, and `ser_out` and `mf_sof` update, only on clock edges where `bit_en` is 1. While `bit_en` is 0 both outputs hold their values.
- R4: The overhead bit of block 1 in subframes 5, 6 and 7 (numbered from 1) carries 0, 1 and 0 in turn.
- R5: In every subframe, the overhead bits of blocks 2, 4, 6 and 8 carry 1, 0, 0 and 1 in turn.
- R6: The overhead bit of block 1 in subframes 1 and 2 is the defect indication, set by `rdi_mode`. With 2'b00 or 2'b11 it is the inverse of `defect_in` at that bit. With 2'b01 it is 1. With 2'b10 it is 0.
- R7: The overhead bit of block 1 in subframes 3 and 4 is 1 when the modulo-2 sum of all payload bits of the previous multiframe is 0, and 0 otherwise. In the first multiframe after reset it is 1.
- R8: The overhead bits of blocks 3, 5 and 7 in subframe n all carry `stuff_in[n-1]`, as sampled on the enabled edge of position 0 of the same multiframe. A change of `stuff_in` later in the multiframe has no effect until the next one.
- R9: `mf_sof` is 1 exactly while `ser_out` holds the bit from position 0, and 0 during every other bit time.
- R10: Overhead slots take their generated value whatever `pay_in` holds at that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies a bit on `pay_in` and advances the position |
| pay_in | input | 1 | Serial payload bit |
| rdi_mode | input | 2 | Defect indication source: 00/11 automatic, 01 forced 1, 10 forced 0 |
| defect_in | input | 1 | Active-high defect condition used in automatic mode |
| stuff_in | input | 7 | Stuff-control value per tributary; bit n-1 belongs to subframe n |
| ser_out | output | 1 | Serial DS3 output bit, registered |
| mf_sof | output | 1 | High during the bit time of the first bit of a multiframe |

## Verification
Two behaviours are hard to reach from the ports. The parity slot depends on the whole previous multiframe, and the stuff bits depend on a value captured at a single edge thousands of bits earlier. The stimulus runs four complete multiframes with controlled payload: random, all ones (even parity), and all zeros except one bit (odd parity). This drives both parity outcomes into the following frames. `stuff_in` is changed in the middle of a multiframe, while C slots of the affected subframe are still to come. On every overhead slot `pay_in` is driven to the opposite of the expected value. Idle gaps with `bit_en` low are inserted throughout, and the defect input flips between the two X slots in automatic mode.

// File: rtl/m23_pkg.sv
// Package m23_pkg
// Shared encodings and constant patterns for the M23 overhead inserter.
// Assumes the fixed DS3 M23 layout of 7 subframes by 8 blocks.
package m23_pkg;

    // Defect indication source select
    typedef enum logic [1:0] {
        RDI_AUTO   = 2'b00,
        RDI_ONE    = 2'b01,
        RDI_ZERO   = 2'b10,
        RDI_AUTO_B = 2'b11
    } rdi_mode_e;

    // Multiframe alignment values for subframes 5..7, index 0 first
    localparam logic [2:0] MALIGN_PAT = 3'b010;

    // Subframe alignment values for blocks 2,4,6,8, index 0 first
    localparam logic [3:0] FALIGN_PAT = 4'b1001;

    // Class of the overhead slot that opens block 1 of a subframe
    typedef enum logic [1:0] {
        LEAD_X = 2'd0,
        LEAD_P = 2'd1,
        LEAD_M = 2'd2
    } lead_kind_e;

endpackage

// File: rtl/m23_pos_ctr.sv
// Module m23_pos_ctr
// Tracks the position inside the multiframe as bit, block and subframe
// indices. Advances only when adv is high. Assumes all counts are at least 2.
module m23_pos_ctr #(
    parameter int NSUB     = 7,
    parameter int NBLK     = 8,
    parameter int BLK_BITS = 85,
    localparam int BW = $clog2(BLK_BITS),
    localparam int KW = $clog2(NBLK),
    localparam int SW = $clog2(NSUB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [BW-1:0] bit_idx,
    output logic [KW-1:0] blk_idx,
    output logic [SW-1:0] sub_idx,
    output logic          at_start,
    output logic          at_end
);

    logic bit_last, blk_last, sub_last;

    // Decode the terminal value of each index
    always_comb begin
        bit_last = (bit_idx == BW'(BLK_BITS - 1));
        blk_last = (blk_idx == KW'(NBLK - 1));
        sub_last = (sub_idx == SW'(NSUB - 1));
        at_end   = bit_last && blk_last && sub_last;
        at_start = (bit_idx == '0) && (blk_idx == '0) && (sub_idx == '0);
    end

    // Nested wrap-around counting of bit, block and subframe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
            blk_idx <= '0;
            sub_idx <= '0;
        end else if (adv) begin
            if (bit_last) begin
                bit_idx <= '0;
                if (blk_last) begin
                    blk_idx <= '0;
                    sub_idx <= sub_last ? '0 : sub_idx + 1'b1;
                end else begin
                    blk_idx <= blk_idx + 1'b1;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/m23_parity.sv
// Module m23_parity
// Accumulates the modulo-2 sum of payload bits over one multiframe and
// holds the previous multiframe's result. Output is 1 for even parity.
// Assumes the last bit of a multiframe is a payload bit.
module m23_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic is_pay,
    input  logic pay_in,
    input  logic mf_end,
    output logic par_bit
);

    logic acc;
    logic prev_sum;
    logic next_acc;

    // Fold the current bit into the running sum when it is payload
    always_comb begin
        next_acc = acc ^ (is_pay & pay_in);
    end

    // Running sum, latched and cleared at the multiframe boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= 1'b0;
            prev_sum <= 1'b0;
        end else if (adv) begin
            if (mf_end) begin
                prev_sum <= next_acc;
                acc      <= 1'b0;
            end else begin
                acc <= next_acc;
            end
        end
    end

    // Even parity of the previous multiframe gives a 1
    assign par_bit = ~prev_sum;

endmodule

// File: rtl/m23_oh_sel.sv
// Module m23_oh_sel
// Combinational choice of the overhead value for the slot that opens the
// current block. Assumes the 7 x 8 M23 layout: X in subframes 1-2,
// P in 3-4, M in 5-7; C in blocks 3,5,7 and F in blocks 2,4,6,8.
module m23_oh_sel
    import m23_pkg::*;
#(
    parameter int NSUB = 7,
    parameter int NBLK = 8,
    localparam int KW = $clog2(NBLK),
    localparam int SW = $clog2(NSUB)
) (
    input  logic [KW-1:0]   blk_idx,
    input  logic [SW-1:0]   sub_idx,
    input  logic [1:0]      rdi_mode,
    input  logic            defect_in,
    input  logic [NSUB-1:0] stuff_q,
    input  logic            par_bit,
    output logic            oh_bit
);

    lead_kind_e lead_kind;
    logic       rdi_bit;
    logic       lead_bit;
    logic [1:0] m_sel;

    // Classify the leading slot of the subframe
    always_comb begin
        if (sub_idx < SW'(2))      lead_kind = LEAD_X;
        else if (sub_idx < SW'(4)) lead_kind = LEAD_P;
        else                       lead_kind = LEAD_M;
        m_sel = 2'(sub_idx - SW'(4));
    end

    // Resolve the defect indication source
    always_comb begin
        case (rdi_mode_e'(rdi_mode))
            RDI_ONE:  rdi_bit = 1'b1;
            RDI_ZERO: rdi_bit = 1'b0;
            default:  rdi_bit = ~defect_in;
        endcase
    end

    // Value of the leading slot
    always_comb begin
        case (lead_kind)
            LEAD_X:  lead_bit = rdi_bit;
            LEAD_P:  lead_bit = par_bit;
            default: lead_bit = (m_sel < 2'd3) ? MALIGN_PAT[2 - m_sel] : 1'b0;
        endcase
    end

    // Pick the slot value from the block index
    always_comb begin
        if (blk_idx == '0)
            oh_bit = lead_bit;
        else if (blk_idx[0])
            oh_bit = FALIGN_PAT[3 - 2'(blk_idx[KW-1:1])];
        else
            oh_bit = stuff_q[sub_idx];
    end

endmodule

// File: rtl/m23_oh_inserter.sv
// Module m23_oh_inserter (top)
// Builds the DS3 M23 multiframe from a serial payload stream: payload bits
// pass through and every overhead slot is overwritten. Output is registered
// and updates only on enabled bits. Assumes stuff_in is stable at the first
// bit of each multiframe, where it is captured.
module m23_oh_inserter #(
    parameter int NSUB     = 7,
    parameter int NBLK     = 8,
    parameter int BLK_BITS = 85
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            pay_in,
    input  logic [1:0]      rdi_mode,
    input  logic            defect_in,
    input  logic [NSUB-1:0] stuff_in,
    output logic            ser_out,
    output logic            mf_sof
);

    localparam int BW = $clog2(BLK_BITS);
    localparam int KW = $clog2(NBLK);
    localparam int SW = $clog2(NSUB);

    logic [BW-1:0]   bit_idx;
    logic [KW-1:0]   blk_idx;
    logic [SW-1:0]   sub_idx;
    logic            at_start;
    logic            at_end;
    logic            is_oh;
    logic            par_bit;
    logic            oh_bit;
    logic [NSUB-1:0] stuff_q;

    // Overhead occupies the first bit of each block
    assign is_oh = (bit_idx == '0);

    m23_pos_ctr #(
        .NSUB(NSUB), .NBLK(NBLK), .BLK_BITS(BLK_BITS)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .adv(bit_en),
        .bit_idx(bit_idx), .blk_idx(blk_idx), .sub_idx(sub_idx),
        .at_start(at_start), .at_end(at_end)
    );

    m23_parity u_par (
        .clk(clk), .rst_n(rst_n), .adv(bit_en),
        .is_pay(~is_oh), .pay_in(pay_in), .mf_end(at_end),
        .par_bit(par_bit)
    );

    m23_oh_sel #(
        .NSUB(NSUB), .NBLK(NBLK)
    ) u_sel (
        .blk_idx(blk_idx), .sub_idx(sub_idx), .rdi_mode(rdi_mode),
        .defect_in(defect_in), .stuff_q(stuff_q), .par_bit(par_bit),
        .oh_bit(oh_bit)
    );

    // Per-tributary capture of the stuff-control value at multiframe start
    for (genvar g = 0; g < NSUB; g++) begin : g_stuff
        always_ff @(posedge clk) begin
            if (!rst_n)
                stuff_q[g] <= 1'b0;
            else if (bit_en && at_start)
                stuff_q[g] <= stuff_in[g];
        end
    end

    // Registered serial output and multiframe start flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
            mf_sof  <= 1'b0;
        end else if (bit_en) begin
            ser_out <= is_oh ? oh_bit : pay_in;
            mf_sof  <= at_start;
        end
    end

endmodule

// File: rtl/m23_oh_checker.sv
// Module m23_oh_checker
// Temporal properties of the overhead inserter, bound to the top module.
// Assumes the default 7 x 8 x 85 layout.
module m23_oh_checker #(
    parameter int NSUB     = 7,
    parameter int NBLK     = 8,
    parameter int BLK_BITS = 85,
    localparam int BW = $clog2(BLK_BITS),
    localparam int KW = $clog2(NBLK),
    localparam int SW = $clog2(NSUB)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic [1:0]    rdi_mode,
    input logic          ser_out,
    input logic          mf_sof,
    input logic [BW-1:0] bit_idx,
    input logic [KW-1:0] blk_idx,
    input logic [SW-1:0] sub_idx
);

    // Outputs hold while no bit is enabled
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ser_out) && $stable(mf_sof)));

    // Multiframe alignment slots in subframes 5..7
    p_mbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == '0 && blk_idx == '0 && sub_idx >= SW'(4))
        |=> (ser_out == ($past(sub_idx) == SW'(5))));

    // Subframe alignment slots F1 and F4 are 1
    p_fone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == '0 && (blk_idx == KW'(1) || blk_idx == KW'(7)))
        |=> ser_out);

    // Subframe alignment slots F2 and F3 are 0
    p_fzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == '0 && (blk_idx == KW'(3) || blk_idx == KW'(5)))
        |=> !ser_out);

    // Forced-one defect indication on X slots
    p_xone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == '0 && blk_idx == '0 && sub_idx < SW'(2) && rdi_mode == 2'b01)
        |=> ser_out);

    // Forced-zero defect indication on X slots
    p_xzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == '0 && blk_idx == '0 && sub_idx < SW'(2) && rdi_mode == 2'b10)
        |=> !ser_out);

    // Start flag only after the first bit of a multiframe
    p_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !(bit_idx == '0 && blk_idx == '0 && sub_idx == '0)) |=> !mf_sof);

    // Start flag after the first bit of a multiframe
    p_sofon_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == '0 && blk_idx == '0 && sub_idx == '0) |=> mf_sof);

    // Wrap from the last position to position 0
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == BW'(BLK_BITS - 1) && blk_idx == KW'(NBLK - 1)
         && sub_idx == SW'(NSUB - 1))
        |=> (bit_idx == '0 && blk_idx == '0 && sub_idx == '0));

endmodule

bind m23_oh_inserter m23_oh_checker #(
    .NSUB(NSUB), .NBLK(NBLK), .BLK_BITS(BLK_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rdi_mode(rdi_mode),
    .ser_out(ser_out), .mf_sof(mf_sof),
    .bit_idx(bit_idx), .blk_idx(blk_idx), .sub_idx(sub_idx)
);

// File: tb/tb_m23_oh_inserter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each expected output bit from the
// requirements and queues it; the monitor pops and compares.
module tb_m23_oh_inserter;

    localparam int NSUB   = 7;
    localparam int NBLK   = 8;
    localparam int BLKLEN = 85;
    localparam int SUBLEN = NBLK * BLKLEN;
    localparam int MFLEN  = NSUB * SUBLEN;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bit_en;
    logic            pay_in;
    logic [1:0]      rdi_mode;
    logic            defect_in;
    logic [NSUB-1:0] stuff_in;
    logic            ser_out;
    logic            mf_sof;

    typedef struct {
        logic  b;
        logic  s;
        string tag;
        int    pos;
    } exp_t;

    exp_t            exp_q[$];
    int              checks = 0;
    int              fails  = 0;
    int              pos    = 0;
    logic            tb_prev = 1'b0;
    logic            tb_acc  = 1'b0;
    logic [NSUB-1:0] tb_stuff = '0;
    logic            last_b = 1'b0;
    logic            last_s = 1'b0;
    bit              done   = 1'b0;

    always #2 clk = ~clk;

    m23_oh_inserter dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pay_in(pay_in),
        .rdi_mode(rdi_mode), .defect_in(defect_in), .stuff_in(stuff_in),
        .ser_out(ser_out), .mf_sof(mf_sof)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input int p);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pos=%0d actual=%0b expected=%0b", tag, p, act, exp);
        end
    endtask

    // Expected overhead value and requirement tag for position p
    task automatic model_oh(input int p, output logic v, output string tag);
        int sub, blk;
        sub = p / SUBLEN;
        blk = (p % SUBLEN) / BLKLEN;
        if (blk == 1 || blk == 7) begin v = 1'b1; tag = "R5 R10"; end
        else if (blk == 3 || blk == 5) begin v = 1'b0; tag = "R5 R10"; end
        else if (blk != 0) begin v = tb_stuff[sub]; tag = "R8 R10"; end
        else if (sub < 2) begin
            tag = "R6 R10";
            if (rdi_mode == 2'b01) v = 1'b1;
            else if (rdi_mode == 2'b10) v = 1'b0;
            else v = ~defect_in;
        end else if (sub < 4) begin v = ~tb_prev; tag = "R7 R10"; end
        else begin v = (sub == 5); tag = "R4 R10"; end
    endtask

    // Drive one enabled bit; overhead slots get the opposite of the expected value
    task automatic send_bit(input logic pay);
        exp_t  e;
        logic  v;
        string tag;
        @(negedge clk);
        if (pos == 0) tb_stuff = stuff_in;
        if ((pos % BLKLEN) == 0) begin
            model_oh(pos, v, tag);
            pay_in = ~v;
        end else begin
            v      = pay;
            tag    = "R2";
            pay_in = pay;
            tb_acc = tb_acc ^ pay;
        end
        bit_en = 1'b1;
        @(posedge clk);
        #1;
        e.b = v; e.s = (pos == 0); e.tag = tag; e.pos = pos;
        exp_q.push_back(e);
        last_b = v;
        last_s = (pos == 0);
        if (pos == MFLEN - 1) begin
            tb_prev = tb_acc;
            tb_acc  = 1'b0;
            pos     = 0;
        end else begin
            pos++;
        end
    endtask

    // Idle cycles with bit_en low, then confirm outputs held (R3)
    task automatic idle(input int n);
        @(negedge clk);
        bit_en = 1'b0;
        pay_in = ~pay_in;
        repeat (n) @(negedge clk);
        chk("R3 hold ser_out", ser_out, last_b, pos);
        chk("R3 hold mf_sof", mf_sof, last_s, pos);
    endtask

    // Monitor: compare produced bits with queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, ser_out, e.b, e.pos);
                chk("R9 mf_sof", mf_sof, e.s, e.pos);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Stimulus
    initial begin
        rst_n = 1'b0; bit_en = 1'b0; pay_in = 1'b0;
        rdi_mode = 2'b00; defect_in = 1'b0; stuff_in = 7'b1010101;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ser_out", ser_out, 1'b0, 0);
        chk("R1 reset mf_sof", mf_sof, 1'b0, 0);
        for (int mf = 0; mf < 4; mf++) begin
            case (mf)
                0: begin rdi_mode = 2'b00; defect_in = 1'b0; stuff_in = 7'b1010101; end
                1: begin rdi_mode = 2'b10; defect_in = 1'b0; stuff_in = 7'b0110011; end
                2: begin rdi_mode = 2'b01; defect_in = 1'b1; end
                default: begin rdi_mode = 2'b11; defect_in = 1'b1; stuff_in = 7'b0001000; end
            endcase
            for (int p = 0; p < MFLEN; p++) begin
                logic pb;
                // R8: change stuff_in mid-multiframe, must wait for next frame
                if (mf == 1 && p == 1000) stuff_in = 7'b1111111;
                if (mf == 3 && p == SUBLEN) defect_in = 1'b0;
                case (mf)
                    1:       pb = 1'b1;
                    2:       pb = (p == 100);
                    default: pb = 1'($urandom % 2);
                endcase
                send_bit(pb);
                if ((p % 53) == 17) idle(2);
            end
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule